// File: doc/BRIEF.md
# CPU Wait-State Merger with Timeout

This block produces the single active-low WAIT line of an 8-bit CPU. It gathers stall requests from several sources. Two external peripherals, the graphics section and the disk controller, each drive an active-low wait line. A serial network board raises an active-high wait request. The block also makes its own automatic stalls: one wait state at the start of each video-memory access, and one extra wait state after the network board drops its request.

A watchdog counter advances on a 2 MHz clock enable while any stall is requested. After 64 such ticks, which is 32 microseconds, the block releases WAIT and holds it released until every request drops. A hung peripheral therefore cannot freeze the processor. A control-port bit turns the automatic stalls on or off. The external requests are always honoured.

Top module: `cpu_wait_merge`

## Requirements
- R1: While `gfx_wait_n` or `dsk_wait_n` is low, `wait_n` is low in the same cycle, unless the timeout has expired.
- R2: While `net_req` is high, `wait_n` is low in the same cycle, unless the timeout has expired.
- R3: With `auto_en` high, a video access (`vid_sel` high) drives `wait_n` low only in its first clock cycle. Later cycles of the same access do not stall. A fresh access, after `vid_sel` has been low for at least one cycle, stalls again.
- R4: With `auto_en` high, `wait_n` stays low for one extra cycle after `net_req` falls.
- R5: With `auto_en` low, video accesses cause no stall and the extra cycle after `net_req` is not added.
- R6: After 64 `tick_en` pulses have been sampled on clock edges while a request is active, `wait_n` is forced high. It stays high while the request remains.
- R7: The timeout count returns to zero in any cycle with no request. A later request therefore gets the full 64 ticks.
- R8: In reset with all requests idle, `wait_n` is high and the timeout count is zero.
- R9: Only clock edges with `tick_en` high advance the timeout. A request held without ticks is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| tick_en | input | 1 | 2 MHz enable that advances the timeout count |
| auto_en | input | 1 | Enables the automatic video and network stalls |
| vid_sel | input | 1 | Video-memory access strobe, high for the whole access |
| net_req | input | 1 | Wait request from the serial network board, active high |
| gfx_wait_n | input | 1 | Graphics-section wait request, active low |
| dsk_wait_n | input | 1 | Disk-controller wait request, active low |
| wait_n | output | 1 | Merged CPU WAIT, active low |

## Verification
Suppose the stored previous value of the video strobe or the network request goes wrong. Then the port shows a missing wait, an extra wait on a later cycle of a video access, or a stretch of the wrong length, and each of these appears one clock after the faulty edge. A fault in the timeout count moves the release of WAIT away from the cycle after the 64th tick. If the count does not clear, a later request is released too early. Each of these shows up within one request window of at most 130 cycles.

// File: rtl/cpu_wait_pkg.sv
package cpu_wait_pkg;
  // automatic stall sources generated inside the block
  typedef struct packed {
    logic vid_first;  // first cycle of a video access
    logic net_hold;   // extra cycle after the network request
  } auto_wait_t;
endpackage

// File: rtl/wait_auto_gen.sv
module wait_auto_gen
  import cpu_wait_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       vid_sel,
  input  logic       net_req,
  output auto_wait_t aw
);
  logic vid_q, vid_d;
  logic net_q, net_d;

  always_comb begin
    vid_d = vid_sel;
    net_d = net_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= 1'b0;
      net_q <= 1'b0;
    end else begin
      vid_q <= vid_d;
      net_q <= net_d;
    end
  end

  always_comb begin
    aw.vid_first = auto_en & vid_sel & ~vid_q;
    aw.net_hold  = auto_en & net_q;
  end

  // R3
  vid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw.vid_first |=> !aw.vid_first);

  // R4
  net_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_req |=> (aw.net_hold || !auto_en));
endmodule

// File: rtl/wait_timeout.sv
module wait_timeout #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic req,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!req)
      cnt_d = '0;
    else if (tick_en && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == CNT_MAX);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && req) |=> expired);

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (cnt_q == '0));
endmodule

// File: rtl/cpu_wait_merge.sv
module cpu_wait_merge
  import cpu_wait_pkg::*;
#(
  parameter int TICK_LIMIT = 64,
  parameter int N_EXT      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic auto_en,
  input  logic vid_sel,
  input  logic net_req,
  input  logic gfx_wait_n,
  input  logic dsk_wait_n,
  output logic wait_n
);
  logic [N_EXT-1:0] ext_n;
  logic [N_EXT-1:0] ext_act;
  auto_wait_t       aw;
  logic             req;
  logic             expired;

  assign ext_n = {dsk_wait_n, gfx_wait_n};

  genvar gi;
  generate
    for (gi = 0; gi < N_EXT; gi++) begin : g_ext
      assign ext_act[gi] = ~ext_n[gi];
    end
  endgenerate

  wait_auto_gen u_auto (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_en (auto_en),
    .vid_sel (vid_sel),
    .net_req (net_req),
    .aw      (aw)
  );

  always_comb begin
    req = (|ext_act) | net_req | aw.vid_first | aw.net_hold;
  end

  wait_timeout #(.LIMIT(TICK_LIMIT)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .req     (req),
    .expired (expired)
  );

  assign wait_n = ~(req & ~expired);

  // R1
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfx_wait_n && !expired) |-> !wait_n);
endmodule

// File: tb/cpu_wait_merge_tb.sv
module cpu_wait_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 64;

  logic clk = 1'b0;
  logic rst_n, tick_en, auto_en, vid_sel, net_req, gfx_wait_n, dsk_wait_n;
  logic wait_n;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic  exp_n;
    string tag;
  } item_t;
  item_t sb[$];

  // model state
  logic m_vid_prev = 1'b0;
  logic m_net_prev = 1'b0;
  int   m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_wait_merge u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .auto_en(auto_en),
    .vid_sel(vid_sel), .net_req(net_req), .gfx_wait_n(gfx_wait_n),
    .dsk_wait_n(dsk_wait_n), .wait_n(wait_n)
  );

  task automatic drive(input logic vid, input logic net, input logic gn,
                       input logic dn, input logic ae, input logic tk,
                       input string tag);
    logic raw;
    item_t it;
    @(posedge clk); #1;
    vid_sel = vid; net_req = net; gfx_wait_n = gn; dsk_wait_n = dn;
    auto_en = ae; tick_en = tk;
    raw = (ae & vid & ~m_vid_prev) | net | (ae & m_net_prev) | ~gn | ~dn;
    it.exp_n = ~(raw && (m_cnt < LIMIT));
    it.tag = tag;
    sb.push_back(it);
    m_vid_prev = vid;
    m_net_prev = net;
    if (!raw) m_cnt = 0;
    else if (tk && m_cnt < LIMIT) m_cnt = m_cnt + 1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if (wait_n !== it.exp_n) begin
          n_fail++;
          $display("FAIL %s: wait_n=%b expected %b at %0t", it.tag, wait_n, it.exp_n, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run incomplete, actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; auto_en = 1'b1; vid_sel = 1'b0;
    net_req = 1'b0; gfx_wait_n = 1'b1; dsk_wait_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (wait_n !== 1'b1) begin // R8
      n_fail++;
      $display("FAIL R8: wait_n=%b expected 1 in reset", wait_n);
    end
    rst_n = 1'b1;

    // R8 idle after reset
    repeat (2) drive(0, 0, 1, 1, 1, 1, "R8");
    // R1 graphics wait
    repeat (3) drive(0, 0, 0, 1, 1, 1, "R1");
    drive(0, 0, 1, 1, 1, 1, "R1");
    // R1 disk wait
    repeat (2) drive(0, 0, 1, 0, 1, 0, "R1");
    drive(0, 0, 1, 1, 1, 0, "R1");
    // R2 / R4 network request with stretch
    repeat (2) drive(0, 1, 1, 1, 1, 0, "R2");
    drive(0, 0, 1, 1, 1, 0, "R4");
    drive(0, 0, 1, 1, 1, 0, "R4");
    // R3 video access: first cycle only
    repeat (3) drive(1, 0, 1, 1, 1, 0, "R3");
    drive(0, 0, 1, 1, 1, 0, "R3");
    drive(1, 0, 1, 1, 1, 0, "R3");
    drive(1, 0, 1, 1, 1, 0, "R3");
    drive(0, 0, 1, 1, 1, 0, "R3");
    // R5 automatic stalls disabled
    repeat (2) drive(1, 0, 1, 1, 0, 0, "R5");
    drive(0, 0, 1, 1, 0, 0, "R5");
    drive(0, 1, 1, 1, 0, 0, "R5");
    drive(0, 0, 1, 1, 0, 0, "R5");
    // R6 / R9 timeout with a tick every other cycle
    for (int i = 0; i < 140; i++) drive(0, 0, 0, 1, 1, i[0], "R6");
    // R7 release clears count, fresh window
    repeat (2) drive(0, 0, 1, 1, 1, 1, "R7");
    for (int i = 0; i < 70; i++) drive(0, 0, 0, 1, 1, 1, "R7");
    drive(0, 0, 1, 1, 1, 1, "R7");
    // R9 no ticks: never released
    for (int i = 0; i < 100; i++) drive(0, 0, 1, 0, 1, 0, "R9");
    drive(0, 0, 1, 1, 1, 0, "R9");
    // R6 timeout on a network request, then stretch after release
    for (int i = 0; i < 66; i++) drive(0, 1, 1, 1, 1, 1, "R6");
    drive(0, 0, 1, 1, 1, 1, "R4");
    drive(0, 0, 1, 1, 1, 1, "R4");

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule